// File: doc/BRIEF.md
# Host-Driven Two-Channel Byte Mailbox

This block is a slave-mode parallel port that an external host processor reaches over its own bus. It holds two byte-wide channels. Each channel has an inbound buffer written by the host, an outbound buffer read by the host, and a full flag for each of the two. The local logic reaches the buffers through a small register-style port and receives two shared interrupt requests. One request fires when an inbound buffer becomes full. The other fires when an outbound buffer becomes empty.

The host side can be wired in one of two ways. The first is a single direction line qualified by an active-low strobe. The second is a pair of separate active-low read and write strobes. A mode input selects between one channel, where every host access goes to channel 0, and two channels, where a host select line picks the channel. Host strobes are asynchronous to the local clock. They pass through a two-stage synchroniser, and each access takes effect when its strobe ends. An enable input gates the whole host side.

Top module: `host_dual_buffer`

## Requirements
- R1: While `rst_n` is low, `ibf`, `obf`, `irq_ibf` and `irq_obe` are all 0, and both buffers of both channels are cleared to 0.
- R2: When `en` is 0 at the end of a host strobe, that access changes no flag and no buffer.
- R3: With `sep_strobes`=0, an access is `h_stb_n` low while `h_cs_n` is low: a write when `h_rw`=0 and a read when `h_rw`=1, and `h_rd_n`/`h_wr_n` are ignored. With `sep_strobes`=1, `h_wr_n` low is a write and `h_rd_n` low is a read, and `h_stb_n`/`h_rw` are ignored.
- R4: A host write loads `h_din` into the selected channel's inbound buffer and sets its `ibf` bit. This happens at the third rising clock edge after the strobe is released.
- R5: `h_dout` continuously shows the selected channel's outbound buffer. A host read clears that channel's `obf` bit at the third rising edge after the strobe is released.
- R6: With `dual_mode`=0, `h_s1` is ignored and host accesses use channel 0. With `dual_mode`=1, `h_s1`=0 selects channel 0 and `h_s1`=1 selects channel 1.
- R7: `l_rdata` shows the inbound buffer of channel `l_sel`. A cycle with `l_re`=1 clears `ibf[l_sel]` at the next edge. A cycle with `l_we`=1 writes `l_wdata` to outbound buffer `l_sel` and sets `obf[l_sel]` at the next edge.
- R8: `irq_ibf` is high for exactly the one cycle after any `ibf` bit goes from 0 to 1. A bit that stays at 1 raises no further pulse.
- R9: `irq_obe` is high for exactly the one cycle after any `obf` bit goes from 1 to 0, which is the moment that channel's output-empty condition rises.
- R10: When a host write and a local read hit the same channel in the same cycle, `ibf` ends at 1. When a local write and a host read clear hit the same channel in the same cycle, `obf` ends at 1.
- R11: A strobe given while `h_cs_n` is high changes no flag and no buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Host interface enable |
| dual_mode | input | 1 | 0: one channel, 1: two channels chosen by `h_s1` |
| sep_strobes | input | 1 | 0: direction line plus strobe, 1: separate read/write strobes |
| h_cs_n | input | 1 | Host chip select, active low |
| h_s1 | input | 1 | Host channel select |
| h_rw | input | 1 | Host direction, 1 = read (combined style) |
| h_stb_n | input | 1 | Host strobe, active low (combined style) |
| h_rd_n | input | 1 | Host read strobe, active low (separate style) |
| h_wr_n | input | 1 | Host write strobe, active low (separate style) |
| h_din | input | W | Host write data |
| h_dout | output | W | Outbound buffer of the selected channel |
| l_sel | input | 1 | Local channel select |
| l_re | input | 1 | Local read of the inbound buffer (clears `ibf`) |
| l_we | input | 1 | Local write of the outbound buffer (sets `obf`) |
| l_wdata | input | W | Local write data |
| l_rdata | output | W | Inbound buffer of channel `l_sel` |
| ibf | output | 2 | Inbound full flags, bit per channel |
| obf | output | 2 | Outbound full flags, bit per channel |
| irq_ibf | output | 1 | Shared inbound-full request pulse |
| irq_obe | output | 1 | Shared outbound-empty request pulse |

## Verification
Two pairs of actions can land in the same clock cycle. A host write can complete in the same cycle as a local read of that channel's inbound buffer. A local write to an outbound buffer can coincide with the end of a host read of that same buffer. The bench releases a host strobe and then times a local access so that it is active exactly at the completion edge, three edges after release. It then checks that the full flag stays set and that the request pulses follow the flag values the reference model predicts.

// File: rtl/host_dual_buffer.sv
module host_dual_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dual_mode,
  input  logic         sep_strobes,
  input  logic         h_cs_n,
  input  logic         h_s1,
  input  logic         h_rw,
  input  logic         h_stb_n,
  input  logic         h_rd_n,
  input  logic         h_wr_n,
  input  logic [W-1:0] h_din,
  output logic [W-1:0] h_dout,
  input  logic         l_sel,
  input  logic         l_re,
  input  logic         l_we,
  input  logic [W-1:0] l_wdata,
  output logic [W-1:0] l_rdata,
  output logic [1:0]   ibf,
  output logic [1:0]   obf,
  output logic         irq_ibf,
  output logic         irq_obe
);

  logic         wr_req, rd_req, h_ch;
  logic [2:0]   wsync, rsync;
  logic         wr_commit, rd_commit;
  logic [W-1:0] hold_d;
  logic         wr_ch, rd_ch;
  logic [W-1:0] ib [2];
  logic [W-1:0] ob [2];
  logic [1:0]   ibf_q, obf_q;

  assign h_ch   = dual_mode & h_s1;
  assign wr_req = en & ~h_cs_n & (sep_strobes ? ~h_wr_n : (~h_stb_n & ~h_rw));
  assign rd_req = en & ~h_cs_n & (sep_strobes ? ~h_rd_n : (~h_stb_n &  h_rw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsync <= '0;
      rsync <= '0;
    end else begin
      wsync <= {wsync[1:0], wr_req};
      rsync <= {rsync[1:0], rd_req};
    end
  end

  assign wr_commit = en & wsync[2] & ~wsync[1];
  assign rd_commit = en & rsync[2] & ~rsync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d <= '0;
      wr_ch  <= 1'b0;
      rd_ch  <= 1'b0;
    end else begin
      if (wsync[1]) begin
        hold_d <= h_din;
        wr_ch  <= h_ch;
      end
      if (rsync[1]) rd_ch <= h_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        ib[c] <= '0;
        ob[c] <= '0;
      end
      ibf <= '0;
      obf <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (wr_commit && wr_ch == c[0]) begin
          ib[c]  <= hold_d;
          ibf[c] <= 1'b1;
        end else if (l_re && l_sel == c[0]) begin
          ibf[c] <= 1'b0;
        end
        if (l_we && l_sel == c[0]) begin
          ob[c]  <= l_wdata;
          obf[c] <= 1'b1;
        end else if (rd_commit && rd_ch == c[0]) begin
          obf[c] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= '0;
      obf_q <= '0;
    end else begin
      ibf_q <= ibf;
      obf_q <= obf;
    end
  end

  assign irq_ibf = |(ibf & ~ibf_q);
  assign irq_obe = |(obf_q & ~obf);
  assign l_rdata = ib[l_sel];
  assign h_dout  = ob[h_ch];

  a_r8_ibf_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ibf |=> !irq_ibf);
  a_r9_obe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_obe |=> !irq_obe);
  a_r8_ibf_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ibf |-> $past(wr_commit));
  a_r9_obe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    irq_obe |-> $past(rd_commit));
  a_r4_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> ibf[$past(wr_ch)]);
  a_r5_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_commit && !(l_we && l_sel == rd_ch)) |=> !obf[$past(rd_ch)]);
  a_r7_local_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (l_re && !(wr_commit && wr_ch == l_sel)) |=> !ibf[$past(l_sel)]);
  a_r7_local_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    l_we |=> obf[$past(l_sel)]);

endmodule

// File: tb/host_dual_buffer_tb.sv
module host_dual_buffer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic en = 0, dual_mode = 0, sep_strobes = 1;
  logic h_cs_n = 0, h_s1 = 0, h_rw = 0, h_stb_n = 1, h_rd_n = 1, h_wr_n = 1;
  logic [7:0] h_din = 0, h_dout, l_wdata = 0, l_rdata;
  logic l_sel = 0, l_re = 0, l_we = 0;
  logic [1:0] ibf, obf;
  logic irq_ibf, irq_obe;

  host_dual_buffer #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .dual_mode(dual_mode), .sep_strobes(sep_strobes),
    .h_cs_n(h_cs_n), .h_s1(h_s1), .h_rw(h_rw), .h_stb_n(h_stb_n), .h_rd_n(h_rd_n),
    .h_wr_n(h_wr_n), .h_din(h_din), .h_dout(h_dout), .l_sel(l_sel), .l_re(l_re),
    .l_we(l_we), .l_wdata(l_wdata), .l_rdata(l_rdata), .ibf(ibf), .obf(obf),
    .irq_ibf(irq_ibf), .irq_obe(irq_obe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  logic [7:0] ib_m [2];
  logic [7:0] ob_m [2];
  logic [1:0] ibf_m = 0, obf_m = 0;
  bit ei_m = 0, eo_m = 0;
  int q_due[$], q_kind[$], q_ch[$], q_dat[$];

  initial begin
    ib_m[0] = 0; ib_m[1] = 0; ob_m[0] = 0; ob_m[1] = 0;
  end

  always @(posedge clk) begin
    logic [1:0] pi, po;
    cyc = cyc + 1;
    pi = ibf_m; po = obf_m;
    if (!rst_n) begin
      ibf_m = 0; obf_m = 0; ei_m = 0; eo_m = 0;
      ib_m[0] = 0; ib_m[1] = 0; ob_m[0] = 0; ob_m[1] = 0;
    end else begin
      if (l_re) ibf_m[l_sel] = 1'b0;
      if (l_we) begin ob_m[l_sel] = l_wdata; obf_m[l_sel] = 1'b1; end
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        int k, c, d;
        k = q_kind.pop_front(); c = q_ch.pop_front(); d = q_dat.pop_front();
        void'(q_due.pop_front());
        if (k == 0) begin ib_m[c] = d[7:0]; ibf_m[c] = 1'b1; end
        else if (!(l_we && l_sel == c[0])) obf_m[c] = 1'b0;
      end
      ei_m = |(ibf_m & ~pi);
      eo_m = |(po & ~obf_m);
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk("R4 ibf", ibf, ibf_m);
      chk("R5 obf", obf, obf_m);
      chk("R8 irq_ibf", irq_ibf, ei_m);
      chk("R9 irq_obe", irq_obe, eo_m);
      chk("R7 l_rdata", l_rdata, ib_m[l_sel]);
      chk("R5 h_dout", h_dout, ob_m[dual_mode & h_s1]);
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  // kind: 0 write, 1 read; conf: 1 = local access timed onto completion edge
  task automatic host_access(bit rd, bit use_sep, bit s1, logic [7:0] d, bit conf);
    int n, ch;
    tick();
    h_s1 = s1; h_din = d; h_rw = rd;
    tick();
    if (use_sep) begin if (rd) h_rd_n = 0; else h_wr_n = 0; end
    else h_stb_n = 0;
    repeat (4) tick();
    h_rd_n = 1; h_wr_n = 1; h_stb_n = 1;
    n = cyc;
    ch = dual_mode & s1;
    if (en && !h_cs_n && use_sep == sep_strobes) begin
      q_due.push_back(n + 3); q_kind.push_back(rd); q_ch.push_back(ch); q_dat.push_back(d);
    end
    if (conf) begin
      while (cyc < n + 2) @(negedge clk);
      #1;
      l_sel = ch[0];
      if (rd) begin l_we = 1; l_wdata = 8'hC3; end else l_re = 1;
      tick();
      l_re = 0; l_we = 0;
    end
    repeat (5) tick();
  endtask

  task automatic local_rd(bit c);
    l_sel = c; l_re = 1; tick(); l_re = 0; tick();
  endtask

  task automatic local_wr(bit c, logic [7:0] d);
    l_sel = c; l_wdata = d; l_we = 1; tick(); l_we = 0; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ibf", ibf, 0);
    chk("R1 reset obf", obf, 0);
    chk("R1 reset irq", {irq_ibf, irq_obe}, 0);
    chk("R1 reset data", l_rdata, 0);
    #1; rst_n = 1; en = 1;
    repeat (2) tick();

    host_access(0, 1, 0, 8'hA5, 0);
    l_sel = 0; tick();
    chk("R4 write ch0 flag", ibf, 2'b01);
    chk("R4 write ch0 data", l_rdata, 8'hA5);

    host_access(0, 1, 1, 8'h3C, 0);
    l_sel = 0; tick();
    chk("R6 single mode ignores s1 data", l_rdata, 8'h3C);
    chk("R6 single mode ignores s1 flag", ibf, 2'b01);

    local_rd(0);
    chk("R7 local read clears ibf", ibf, 2'b00);

    dual_mode = 1;
    host_access(0, 1, 1, 8'h5A, 0);
    l_sel = 1; tick();
    chk("R6 dual mode s1 selects ch1", ibf, 2'b10);
    chk("R6 ch1 data", l_rdata, 8'h5A);

    local_wr(0, 8'h11);
    local_wr(1, 8'h22);
    chk("R7 local write sets obf", obf, 2'b11);
    host_access(1, 1, 0, 8'h00, 0);
    chk("R5 host read ch0 clears obf", obf, 2'b10);

    sep_strobes = 0;
    host_access(0, 0, 0, 8'h77, 0);
    chk("R3 combined style write", ibf, 2'b11);
    host_access(1, 0, 1, 8'h00, 0);
    chk("R3 combined style read", obf, 2'b00);

    local_rd(0); local_rd(1);
    host_access(0, 1, 0, 8'h99, 0);
    chk("R3 separate strobes ignored in combined style", ibf, 2'b00);

    en = 0; tick();
    host_access(0, 0, 0, 8'h44, 0);
    chk("R2 disabled write ignored", ibf, 2'b00);
    local_wr(1, 8'h66);
    host_access(1, 0, 1, 8'h00, 0);
    chk("R2 disabled read ignored", obf, 2'b10);
    en = 1; tick();

    h_cs_n = 1;
    host_access(0, 0, 1, 8'h55, 0);
    chk("R11 deselected write ignored", ibf, 2'b00);
    h_cs_n = 0; tick();

    host_access(0, 0, 0, 8'hE1, 1);
    chk("R10 host write beats local read", ibf, 2'b01);
    host_access(1, 0, 1, 8'h00, 1);
    chk("R10 local write beats host read", obf, 2'b10);
    l_sel = 1; tick();
    chk("R10 outbound data from local write", h_dout, 8'hC3);

    host_access(0, 0, 0, 8'h12, 0);
    chk("R8 ibf held high stays set", ibf, 2'b01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule